// File: doc/BRIEF.md
# Protected Register Write Sequencer

This block holds one control register that ordinary stores cannot change. A peripheral store bus (write strobe, address, data) reaches three addresses: a command port, the protected register, and a status register. Software writes the protected register only by a four-store procedure:

- a key byte to the command port;
- the wanted value to the protected register;
- the bitwise complement of that value;
- the wanted value once more.

A store that breaks the procedure ends it. The protected register keeps its old contents and a sticky sequence-error flag is set.

Cycles in which the strobe is low may fall between any two steps. The flag stays set until software stores to the status register with bit 0 cleared, or until reset. Both the register contents and the flag drive output ports directly.

Top module: `prot_reg_seq`

## Requirements
- R1: While reset is asserted and after it is released, the protected register holds RESET_VAL (8'h00 by default), the error flag is 0 and no sequence is in progress.
- R2: The procedure begins only on a store of KEY (8'hA5) to CMD_ADDR (address 0). With no procedure in progress, a store to CMD_ADDR with any other value is ignored, and so is any store to PROT_ADDR (address 1): neither changes the register or the flag.
- R3: The first store after the key must go to PROT_ADDR. Its data is captured as the candidate and the register does not change. A store to any other address at this step sets the error flag and aborts the procedure.
- R4: The next store must go to PROT_ADDR and carry the bitwise complement of the candidate. Any other data sets the error flag and aborts the procedure.
- R5: The confirming store must go to PROT_ADDR. At this step, a store to any other address sets the error flag and aborts the procedure.
- R6: The confirming store must carry the candidate unchanged. A mismatch sets the error flag and aborts the procedure.
- R7: When the confirming store matches, the register takes the candidate at that clock edge, with no further delay. Cycles with the strobe low between steps do not disturb the procedure.
- R8: The error flag is sticky. It clears only on reset or on a store to STAT_ADDR (address 2) with data bit 0 equal to 0. A store there with bit 0 equal to 1 has no effect. If a status store aborts a procedure, setting the flag wins over clearing it.
- R9: After an abort, the register keeps its earlier value and a new key store is needed. Value, complement and confirm stores without a new key change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Store strobe, one store per cycle in which it is high |
| bus_addr | input | ADDR_W | Store address |
| bus_wdata | input | DATA_W | Store data |
| prot_value | output | DATA_W | Contents of the protected register |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
The bench targets the following cases and the failure each one exposes:

- **Complement step with the value 8'hFF, whose complement is zero.** A design that checks the complement against the wrong operand commits too early or flags an error.
- **Stray stores at every step, including a status store mid-procedure that also requests a clear.** A design that ignores the address at the final step commits garbage. A design that lets the clear win loses the error.
- **Value, complement and confirm stores replayed after an abort, after a wrong key, and after a reset in mid-procedure.** A design that does not return to idle would change the register here.
- **Status store with bit 0 set.** A non-sticky or mis-decoded flag would drop at this store.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_INV   = 2'd2,
        SEQ_CONF  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/prs_decode.sv
module prs_decode #(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 0,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_hit,
    output logic              prot_hit,
    output logic              stat_hit
);
    always_comb begin
        cmd_hit  = we && (addr == CMD_ADDR);
        prot_hit = we && (addr == PROT_ADDR);
        stat_hit = we && (addr == STAT_ADDR);
    end
endmodule

// File: rtl/prs_fsm.sv
module prs_fsm
    import prs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              cmd_hit,
    input  logic              prot_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic              abort,
    output logic [DATA_W-1:0] commit_val
);
    typedef struct packed {
        seq_state_e        state;
        logic [DATA_W-1:0] cand;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d  = fsm_q;
        commit = 1'b0;
        abort  = 1'b0;
        if (we) begin
            unique case (fsm_q.state)
                SEQ_IDLE: begin
                    if (cmd_hit && (wdata == KEY)) fsm_d.state = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (prot_hit) begin
                        fsm_d.cand  = wdata;
                        fsm_d.state = SEQ_INV;
                    end else begin
                        abort       = 1'b1;
                        fsm_d.state = SEQ_IDLE;
                    end
                end
                SEQ_INV: begin
                    if (prot_hit && (wdata == ~fsm_q.cand)) begin
                        fsm_d.state = SEQ_CONF;
                    end else begin
                        abort       = 1'b1;
                        fsm_d.state = SEQ_IDLE;
                    end
                end
                SEQ_CONF: begin
                    if (prot_hit && (wdata == fsm_q.cand)) commit = 1'b1;
                    else abort = 1'b1;
                    fsm_d.state = SEQ_IDLE;
                end
                default: fsm_d.state = SEQ_IDLE;
            endcase
        end
        commit_val = fsm_q.cand;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= SEQ_IDLE;
            fsm_q.cand  <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end
endmodule

// File: rtl/prs_errflag.sv
module prs_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic stat_hit,
    input  logic wbit0,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i)                  flag_d = 1'b1;
        else if (stat_hit && !wbit0) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/prot_reg_seq.sv
module prot_reg_seq #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 0,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2,
    parameter logic [DATA_W-1:0] KEY       = 8'hA5,
    parameter logic [DATA_W-1:0] RESET_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] prot_value,
    output logic              seq_err
);
    logic              cmd_hit, prot_hit, stat_hit;
    logic              commit, abort;
    logic [DATA_W-1:0] commit_val;
    logic [DATA_W-1:0] prot_d, prot_q;

    prs_decode #(
        .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR),
        .PROT_ADDR(PROT_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_dec (
        .we(bus_we), .addr(bus_addr),
        .cmd_hit(cmd_hit), .prot_hit(prot_hit), .stat_hit(stat_hit)
    );

    prs_fsm #(.DATA_W(DATA_W), .KEY(KEY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .we(bus_we),
        .cmd_hit(cmd_hit), .prot_hit(prot_hit), .wdata(bus_wdata),
        .commit(commit), .abort(abort), .commit_val(commit_val)
    );

    prs_errflag u_err (
        .clk(clk), .rst_n(rst_n), .set_i(abort),
        .stat_hit(stat_hit), .wbit0(bus_wdata[0]), .flag(seq_err)
    );

    always_comb begin
        prot_d = prot_q;
        if (commit) prot_d = commit_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= RESET_VAL;
        else        prot_q <= prot_d;
    end

    assign prot_value = prot_q;
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 1,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] prot_value,
    input logic              seq_err
);
    assert_commit_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_value != $past(prot_value)) |->
            ($past(bus_we && (bus_addr == PROT_ADDR)) && (prot_value == $past(bus_wdata))));

    assert_no_store_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> ($stable(prot_value) && $stable(seq_err)));

    assert_err_rise_on_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(bus_we));

    assert_err_clear_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_err) |-> $past(bus_we && (bus_addr == STAT_ADDR) && !bus_wdata[0]));

    assert_abort_keeps_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $stable(prot_value));
endmodule

bind prot_reg_seq prs_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROT_ADDR(PROT_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .prot_value(prot_value), .seq_err(seq_err)
);

// File: tb/prot_reg_seq_tb.sv
module prot_reg_seq_tb;
    localparam logic [3:0] A_CMD  = 4'h0;
    localparam logic [3:0] A_PROT = 4'h1;
    localparam logic [3:0] A_STAT = 4'h2;
    localparam logic [7:0] KEY    = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] prot_value;
    logic       seq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prot_reg_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .prot_value(prot_value), .seq_err(seq_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_err();
        store(A_STAT, 8'h00);
        chk("R8 clear", {7'b0, seq_err}, 8'h00);
    endtask

    task automatic t_reset();
        chk("R1 reg in reset", prot_value, 8'h00);
        chk("R1 flag in reset", {7'b0, seq_err}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        chk("R1 reg after reset", prot_value, 8'h00);
        chk("R1 flag after reset", {7'b0, seq_err}, 8'h00);
    endtask

    task automatic t_good(input logic [7:0] v, input logic [7:0] old);
        store(A_CMD, KEY);
        store(A_PROT, v);
        chk("R3 candidate does not update", prot_value, old);
        store(A_PROT, ~v);
        chk("R4 complement does not update", prot_value, old);
        store(A_PROT, v);
        chk("R7 commit", prot_value, v);
        chk("R7 no error", {7'b0, seq_err}, 8'h00);
    endtask

    task automatic t_gaps();
        store(A_CMD, KEY); idle(3);
        store(A_PROT, 8'h5C); idle(2);
        store(A_PROT, 8'hA3); idle(4);
        store(A_PROT, 8'h5C);
        chk("R7 commit with gaps", prot_value, 8'h5C);
    endtask

    task automatic t_idle_ignored();
        store(A_CMD, 8'h5A);
        store(A_PROT, 8'h11);
        store(A_PROT, 8'hEE);
        store(A_PROT, 8'h11);
        chk("R2 wrong key reg", prot_value, 8'h5C);
        chk("R2 wrong key flag", {7'b0, seq_err}, 8'h00);
    endtask

    task automatic t_armed_stray();
        store(A_CMD, KEY);
        store(A_CMD, 8'h22);
        chk("R3 stray after key flag", {7'b0, seq_err}, 8'h01);
        chk("R3 stray after key reg", prot_value, 8'h5C);
        clear_err();
    endtask

    task automatic t_bad_inverse();
        store(A_CMD, KEY);
        store(A_PROT, 8'h77);
        store(A_PROT, 8'h77);
        chk("R4 bad complement flag", {7'b0, seq_err}, 8'h01);
        chk("R4 bad complement reg", prot_value, 8'h5C);
        store(A_PROT, 8'h77);
        chk("R9 no key after abort reg", prot_value, 8'h5C);
        clear_err();
    endtask

    task automatic t_stray_confirm();
        store(A_CMD, KEY);
        store(A_PROT, 8'h44);
        store(A_PROT, 8'hBB);
        store(A_CMD, 8'h44);
        chk("R5 stray confirm flag", {7'b0, seq_err}, 8'h01);
        chk("R5 stray confirm reg", prot_value, 8'h5C);
        store(A_PROT, 8'h44);
        chk("R9 late confirm ignored", prot_value, 8'h5C);
        clear_err();
    endtask

    task automatic t_bad_confirm();
        store(A_CMD, KEY);
        store(A_PROT, 8'h44);
        store(A_PROT, 8'hBB);
        store(A_PROT, 8'h45);
        chk("R6 mismatch flag", {7'b0, seq_err}, 8'h01);
        chk("R6 mismatch reg", prot_value, 8'h5C);
    endtask

    task automatic t_sticky();
        idle(3);
        chk("R8 sticky", {7'b0, seq_err}, 8'h01);
        store(A_STAT, 8'h01);
        chk("R8 bit0 one ignored", {7'b0, seq_err}, 8'h01);
        clear_err();
        store(A_CMD, KEY);
        store(A_PROT, 8'h10);
        store(A_STAT, 8'h00);
        chk("R8 set wins over clear", {7'b0, seq_err}, 8'h01);
        clear_err();
    endtask

    task automatic t_mid_reset();
        store(A_CMD, KEY);
        store(A_PROT, 8'h99);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset restores default", prot_value, 8'h00);
        store(A_PROT, 8'h66);
        store(A_PROT, 8'h99);
        chk("R1 sequence dropped by reset", prot_value, 8'h00);
        chk("R1 no flag", {7'b0, seq_err}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_good(8'h3C, 8'h00);
        t_good(8'hFF, 8'h3C);
        t_gaps();
        t_idle_ignored();
        t_armed_stray();
        t_bad_inverse();
        t_stray_confirm();
        t_bad_confirm();
        t_sticky();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule